// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between a 32-lane execution unit and the memory system. It accepts one access request for a whole warp: every lane supplies a byte address for a 4-byte word and an active bit. The block sorts the active lanes into aligned 128-byte segments and issues one memory transaction for each distinct segment. Each transaction carries the segment base address and a lane mask that lists every lane the transaction serves.

The number of transactions follows the address pattern. Lanes that read consecutive words from one aligned segment produce a single transaction. Lanes spread across different segments produce one transaction each, up to 32. Transactions leave over a valid/ready handshake and come out one per cycle while the consumer accepts them. A one-cycle done pulse closes each warp request. The next request is accepted only after the current one has finished.

Top module: `warp_coalescer`

## Requirements
- R1: During reset and right after it, in_ready is 1, out_valid is 0 and done is 0.
- R2: When 32 active lanes address consecutive 4-byte words starting on a 128-byte boundary, exactly one transaction is issued. Its out_mask is all ones and its out_base is the first lane's address.
- R3: When every active lane falls in a different segment (for example a lane stride of 4096 bytes), one transaction is issued per lane, and each mask has exactly one bit set.
- R4: The number of transactions equals the number of distinct segments touched by active lanes. out_base is a lane address with its low 7 bits cleared. Bit k of out_mask is 1 exactly when lane k is active, is not yet served, and lies in that segment. No lane is served twice.
- R5: Transactions are issued in the order of the lowest-numbered lane still pending, not in address order.
- R6: Inactive lanes never appear in a mask and never cause a transaction, whatever their addresses.
- R7: A request with no active lanes issues no transaction, and done is 1 in the cycle after the request is accepted.
- R8: in_ready is 0 from the acceptance of a request with active lanes until its last transaction has been accepted. A request asserted on in_valid during that time is ignored.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_base and out_mask hold their values in the next cycle, and no lane is lost.
- R10: done is 1 for exactly the cycle after the last transaction of a request is accepted, and in_ready is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A warp request is offered |
| in_ready | output | 1 | The block can accept a warp request |
| in_addr | input | 1024 | Lane byte addresses; lane k occupies bits [32k+31:32k] |
| in_active | input | 32 | Active bit per lane; bit k is lane k |
| out_valid | output | 1 | A transaction is offered |
| out_ready | input | 1 | The consumer takes the transaction |
| out_base | output | 32 | Segment base address, low 7 bits zero |
| out_mask | output | 32 | Lanes served by this transaction; bit k is lane k |
| done | output | 1 | One-cycle pulse at the end of a warp request |

## Verification
The done pulse of one request and the acceptance of the next request can fall in the same cycle, because in_ready rises together with done. The bench provokes this by queueing requests so that the next one is already waiting when the last transaction goes out, and by sending empty requests back to back. In each such cycle it checks that done matches the expected timing, that in_ready is high, and that the first transaction of the new request starts only in the following cycle and matches the scoreboard. A downstream stall on the final transaction is also covered, to show that done waits for the handshake and does not follow the offer.

// File: rtl/wc_pkg.sv
package wc_pkg;

    typedef enum logic {
        WC_IDLE  = 1'b0,
        WC_ISSUE = 1'b1
    } wc_state_e;

endpackage

// File: rtl/wc_lane_pick.sv
module wc_lane_pick #(
    parameter int LANES = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

    // R5: the chosen lane is pending and no lower lane is pending
    a_r5_lowest_lane: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[idx] && ((req & ((LANES'(1) << idx) - LANES'(1))) == '0)));

endmodule

// File: rtl/wc_seg_match.sv
module wc_seg_match #(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 32,
    parameter int SEG_LSB = 7
) (
    input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0]             pend,
    input  logic [ADDR_W-1:0]            seg_base,
    output logic [LANES-1:0]             hit
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] diff;
        assign diff   = lane_addr[g] ^ seg_base;
        assign hit[g] = pend[g] && ((diff >> SEG_LSB) == '0);
    end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import wc_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]        in_active,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [ADDR_W-1:0]       out_base,
    output logic [LANES-1:0]        out_mask,
    output logic                    done
);

    localparam int SEG_LSB = $clog2(SEG_BYTES);
    localparam int IDX_W   = $clog2(LANES);
    localparam logic [ADDR_W-1:0] SEG_MASK = ADDR_W'(SEG_BYTES - 1);

    typedef struct packed {
        wc_state_e                    st;
        logic [LANES-1:0]             pend;
        logic [LANES-1:0][ADDR_W-1:0] addr;
        logic                         done;
    } state_t;

    state_t state_d, state_q;

    logic [LANES-1:0][ADDR_W-1:0] in_vec;
    logic                         pick_any;
    logic [IDX_W-1:0]             pick_idx;
    logic [ADDR_W-1:0]            sel_base;
    logic [LANES-1:0]             seg_hit;
    logic [LANES-1:0]             left_after;

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign in_vec[g] = in_addr[g*ADDR_W +: ADDR_W];
    end

    wc_lane_pick #(
        .LANES (LANES)
    ) i_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (state_q.pend),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    assign sel_base = state_q.addr[pick_idx] & ~SEG_MASK;

    wc_seg_match #(
        .LANES   (LANES),
        .ADDR_W  (ADDR_W),
        .SEG_LSB (SEG_LSB)
    ) i_match (
        .lane_addr (state_q.addr),
        .pend      (state_q.pend),
        .seg_base  (sel_base),
        .hit       (seg_hit)
    );

    assign left_after = state_q.pend & ~seg_hit;

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        unique case (state_q.st)
            WC_IDLE: begin
                if (in_valid) begin
                    state_d.addr = in_vec;
                    state_d.pend = in_active;
                    if (in_active == '0) begin
                        state_d.done = 1'b1;
                    end else begin
                        state_d.st = WC_ISSUE;
                    end
                end
            end
            WC_ISSUE: begin
                if (out_ready) begin
                    state_d.pend = left_after;
                    if (left_after == '0) begin
                        state_d.st   = WC_IDLE;
                        state_d.done = 1'b1;
                    end
                end
            end
            default: state_d.st = WC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.st   <= WC_IDLE;
            state_q.pend <= '0;
            state_q.addr <= '0;
            state_q.done <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign in_ready  = (state_q.st == WC_IDLE);
    assign out_valid = (state_q.st == WC_ISSUE) && pick_any;
    assign out_base  = sel_base;
    assign out_mask  = seg_hit;
    assign done      = state_q.done;

    // R9: a stalled offer stays in place
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_base) && $stable(out_mask)));

    // R8: no new request is taken while transactions are pending
    a_r8_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R10: done comes only when the block is free again
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (in_ready && !out_valid));

    // R4: an offered transaction always serves some lane
    a_r4_mask_live: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask != '0));

    // R4: a lane served by an accepted transaction is not served again
    a_r4_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !(out_valid && ((out_mask & $past(out_mask)) != '0)));

    // R7: an empty request finishes right away
    a_r7_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_active == '0)) |=> (done && !out_valid));

endmodule

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;

    localparam int L  = 32;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic            in_ready;
    logic [L*AW-1:0] in_addr;
    logic [L-1:0]    in_active;
    logic            out_valid;
    logic            out_ready;
    logic [AW-1:0]   out_base;
    logic [L-1:0]    out_mask;
    logic            done;

    always #2 clk = ~clk;

    warp_coalescer i_warp_coalescer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_addr   (in_addr),
        .in_active (in_active),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_base  (out_base),
        .out_mask  (out_mask),
        .done      (done)
    );

    typedef struct {
        logic [AW-1:0] base;
        logic [L-1:0]  mask;
        bit            last;
        string         tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   rmode  = 0;
    logic [15:0] lfsr = 16'hACE1;

    bit            done_exp  = 1'b0;
    bit            busy_exp  = 1'b0;
    bit            stall_prv = 1'b0;
    logic [AW-1:0] st_base;
    logic [L-1:0]  st_mask;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        case (rmode)
            0: out_ready = 1'b1;
            1: begin
                lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                out_ready = lfsr[0] | lfsr[5];
            end
            default: out_ready = 1'b0;
        endcase
    end

    task automatic send(input logic [AW-1:0] ad [L], input logic [L-1:0] act,
                        input string tag);
        logic [L-1:0]  p;
        logic [L-1:0]  m;
        logic [AW-1:0] seg;
        int            lo;
        exp_t          e;
        @(posedge clk); #1;
        while (!in_ready) begin
            @(posedge clk); #1;
        end
        p = act;
        while (p != '0) begin
            lo = 0;
            for (int i = L - 1; i >= 0; i--) if (p[i]) lo = i;
            seg = ad[lo] >> 7;
            m   = '0;
            for (int j = 0; j < L; j++) if (p[j] && ((ad[j] >> 7) == seg)) m[j] = 1'b1;
            p      = p & ~m;
            e.base = seg << 7;
            e.mask = m;
            e.last = (p == '0);
            e.tag  = tag;
            sbq.push_back(e);
        end
        for (int k = 0; k < L; k++) in_addr[k*AW +: AW] = ad[k];
        in_active = act;
        in_valid  = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        bit   dn;
        exp_t e;
        if (rst_n) begin
            if (done || done_exp)
                check(done == done_exp, "R7/R10", "done timing", 64'(done), 64'(done_exp));
            if (done)
                check(in_ready, "R10", "in_ready with done", 64'(in_ready), 64'd1);
            if (in_valid)
                check(in_ready == !busy_exp, "R8", "in_ready", 64'(in_ready), 64'(!busy_exp));
            if (stall_prv)
                check(out_valid && out_base == st_base && out_mask == st_mask, "R9",
                      "stall hold", {out_base, out_mask}, {st_base, st_mask});
            dn = 1'b0;
            if (in_valid && in_ready) begin
                if (in_active == '0) dn = 1'b1;
                else busy_exp = 1'b1;
            end
            if (out_valid && out_ready) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R4", "unexpected transaction", {out_base, out_mask}, 64'd0);
                end else begin
                    e = sbq.pop_front();
                    check(out_base == e.base, e.tag, "out_base", 64'(out_base), 64'(e.base));
                    check(out_mask == e.mask, e.tag, "out_mask", 64'(out_mask), 64'(e.mask));
                    if (e.last) begin
                        dn       = 1'b1;
                        busy_exp = 1'b0;
                    end
                end
            end
            stall_prv = out_valid && !out_ready;
            st_base   = out_base;
            st_mask   = out_mask;
            done_exp  = dn;
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [AW-1:0] ad [L];
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_addr   = '0;
        in_active = '0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready && !out_valid && !done, "R1", "in reset",
              {in_ready, out_valid, done}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !out_valid && !done, "R1", "after reset",
              {in_ready, out_valid, done}, 64'h4);

        // R2: contiguous aligned warp
        for (int k = 0; k < L; k++) ad[k] = 32'h0001_0000 + 32'(k) * 4;
        send(ad, '1, "R2");

        // R3: stride 4096, one transaction per lane
        for (int k = 0; k < L; k++) ad[k] = 32'h0020_0000 + 32'(k) * 4096;
        send(ad, '1, "R3");

        // R4: unaligned contiguous run spans two segments
        for (int k = 0; k < L; k++) ad[k] = 32'h0003_0040 + 32'(k) * 4;
        send(ad, '1, "R4");

        // R5: descending addresses, order follows lane number
        for (int k = 0; k < L; k++) ad[k] = 32'h0004_0000 + 32'(L - 1 - k) * 64;
        send(ad, '1, "R5");

        // R6: inactive lanes point at fresh segments and must not appear
        for (int k = 0; k < L; k++) ad[k] = (k % 2 == 0) ? 32'h0005_0000 + 32'(k) * 4
                                                         : 32'h7000_0000 + 32'(k) * 512;
        send(ad, 32'h5555_5555, "R6");

        // R7: empty requests back to back
        send(ad, '0, "R7");
        send(ad, '0, "R7");
        send(ad, '0, "R7");

        // R9: random stalls over a strided warp
        rmode = 1;
        for (int k = 0; k < L; k++) ad[k] = 32'h0060_0000 + 32'(k % 8) * 256 + 32'(k) * 4;
        send(ad, '1, "R9");
        for (int k = 0; k < L; k++) ad[k] = 32'h0070_0000 + 32'(k) * 4096;
        send(ad, 32'hF0F0_0FF0, "R9");

        // R8: hold consumer off, offer a competing request while busy
        wait (sbq.size() == 0);
        rmode = 2;
        for (int k = 0; k < L; k++) ad[k] = 32'h0080_0000 + 32'(k) * 128;
        send(ad, 32'h0000_00FF, "R8");
        in_active = '1;
        in_addr   = '1;
        in_valid  = 1'b1;
        repeat (4) @(posedge clk);
        #1 in_valid = 1'b0;
        rmode = 0;

        // R10: next request waiting while the last transaction stalls
        rmode = 1;
        for (int t = 0; t < 40; t++) begin
            logic [L-1:0] act;
            logic [AW-1:0] bs;
            bs  = $urandom & 32'hFFFF_F000;
            act = (t % 5 == 0) ? '0 : L'($urandom);
            for (int k = 0; k < L; k++)
                ad[k] = bs + 32'($urandom_range(0, 3)) * 128 + 32'($urandom_range(0, 31)) * 4;
            send(ad, act, "R10");
        end

        wait (sbq.size() == 0 && in_ready);
        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule